// File: doc/BRIEF.md
# Streaming Hamming Parity Generator for Flash Pages

This block watches page data go by one byte at a time and builds a 22-bit Hamming check code for every 256-byte chunk. Each chunk's code has two 11-bit halves, a low group and a high group. A single flipped data bit changes both halves at complementary positions. When a stored code is XORed with a code recomputed on the same data, the low group gives the flipped bit's address directly. The low and high groups of that syndrome together cover all eleven bits.

Before each page the controller pulses a clear. It then presents the page bytes on a valid/ready stream. A page-size select chooses one chunk (256 bytes) or two chunks (512 bytes). In the two-chunk setting the second pair of groups is computed independently over bytes 256 to 511. When the last chunk of the page is accepted, the block latches its groups and raises a done flag. It then refuses further bytes until the next clear.

Stream rules: a byte transfers on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while `clr` is high and while `done` is high, and high at all other times. The source may hold `in_valid` low for any number of cycles between bytes. `page_big` must be held steady from the clear until done.

Top module: `hamm_ecc_gen`

## Requirements
- R1: After reset, every parity group output is zero, `done` is low and `in_ready` is high.
- R2: Inside a chunk, data bit k (0..7) of the byte at chunk offset b (0..255) has the 11-bit position p = b*8 + k. Bit j of a chunk's low group is the XOR of all data bits whose position has bit j set.
- R3: Bit j of a chunk's high group is the XOR of all data bits whose position has bit j clear.
- R4: If two pages differ in a single data bit at position p, the XOR of their low groups equals p. The XOR of their low groups with their high groups equals 0x7FF.
- R5: With `page_big` low, `done` rises in the cycle after byte 255 is accepted and not earlier. Groups are latched in slot 0, and slot 1 stays zero.
- R6: With `page_big` high, slot 0 holds the groups of bytes 0..255, latched after byte 255. Slot 1 holds the groups of bytes 256..511 computed from zero. `done` rises only after byte 511.
- R7: While `done` is high, `in_ready` is low and bytes offered with `in_valid` leave all group outputs and `done` unchanged.
- R8: A `clr` cycle drops `in_ready` for that cycle and accepts no byte. After it, all groups, `done` and the byte position return to zero, and the next byte counts as byte 0.
- R9: Cycles with `in_valid` low do not change the running code, whatever `in_data` holds.
- R10: In every latched slot, the low group XOR the high group is either all zeros or all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of code state before a page |
| page_big | input | 1 | 0: page of one 256-byte chunk, 1: page of two chunks |
| in_valid | input | 1 | Byte offered on in_data |
| in_ready | output | 1 | Block accepts a byte this cycle |
| in_data | input | 8 | Page byte |
| par_lo | output | 2x11 | Low parity group per chunk slot (packed, slot 0 in [0]) |
| par_hi | output | 2x11 | High parity group per chunk slot |
| done | output | 1 | Last chunk of the page has been latched |

## Verification
Several page patterns exercise the code. An all-zero page exposes stray constant terms. An all-ones page sums every position, so its low and high groups each equal the XOR of all positions. Random pages with random valid gaps compare both groups against a reference that XORs the positions of set bits, and the gaps would show any accumulation on idle cycles. Pairs of pages that differ in one random bit check the syndrome address law. The two-chunk setting with different data in each half shows that the second pair starts from zero rather than carrying the first.

// File: rtl/hamm_ecc_pkg.sv
package hamm_ecc_pkg;
  localparam int BYTE_W     = 8;
  localparam int BIT_IDX_W  = 3;
  localparam int BYTE_IDX_W = 8;
  localparam int POS_W      = BYTE_IDX_W + BIT_IDX_W;

  typedef struct packed {
    logic [POS_W-1:0] hi;
    logic [POS_W-1:0] lo;
  } ecc_pair_t;
endpackage

// File: rtl/hamm_byte_term.sv
module hamm_byte_term
  import hamm_ecc_pkg::*;
(
  input  logic [BYTE_IDX_W-1:0] byte_idx,
  input  logic [BYTE_W-1:0]     data,
  output ecc_pair_t             term
);
  logic [POS_W-1:0] pos;

  always_comb begin
    term = '0;
    pos  = '0;
    for (int k = 0; k < BYTE_W; k++) begin
      pos = {byte_idx, BIT_IDX_W'(k)};
      for (int j = 0; j < POS_W; j++) begin
        if (data[k]) begin
          if (pos[j]) term.lo[j] = ~term.lo[j];
          else        term.hi[j] = ~term.hi[j];
        end
      end
    end
  end
endmodule

// File: rtl/hamm_ecc_ctrl.sv
module hamm_ecc_ctrl
  import hamm_ecc_pkg::*;
#(
  parameter int MAX_CHUNKS = 2,
  localparam int CHUNK_W = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  page_big,
  input  logic                  in_valid,
  output logic                  in_ready,
  output logic                  accept,
  output logic                  chunk_end,
  output logic [BYTE_IDX_W-1:0] byte_idx,
  output logic [CHUNK_W-1:0]    chunk_idx,
  output logic                  done
);
  logic [CHUNK_W-1:0] last_chunk;

  assign last_chunk = page_big ? CHUNK_W'(MAX_CHUNKS - 1) : '0;
  assign in_ready   = !done && !clr;
  assign accept     = in_valid && in_ready;
  assign chunk_end  = accept && (byte_idx == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_idx  <= '0;
      chunk_idx <= '0;
      done      <= 1'b0;
    end else if (clr) begin
      byte_idx  <= '0;
      chunk_idx <= '0;
      done      <= 1'b0;
    end else if (accept) begin
      byte_idx <= byte_idx + 1'b1;
      if (chunk_end) begin
        if (chunk_idx == last_chunk) done <= 1'b1;
        else                         chunk_idx <= chunk_idx + 1'b1;
      end
    end
  end

  assert_no_accept_when_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> done);
  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (byte_idx == BYTE_IDX_W'($past(byte_idx) + 1'b1)));
  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> $stable(byte_idx));
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (byte_idx == '0 && !done));
endmodule

// File: rtl/hamm_ecc_accum.sv
module hamm_ecc_accum
  import hamm_ecc_pkg::*;
#(
  parameter int MAX_CHUNKS = 2,
  localparam int CHUNK_W = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  accept,
  input  logic                  chunk_end,
  input  logic [BYTE_IDX_W-1:0] byte_idx,
  input  logic [CHUNK_W-1:0]    chunk_idx,
  input  logic [BYTE_W-1:0]     data,
  output ecc_pair_t             slot [MAX_CHUNKS]
);
  ecc_pair_t acc;
  ecc_pair_t term;
  ecc_pair_t acc_next;

  hamm_byte_term u_term (
    .byte_idx (byte_idx),
    .data     (data),
    .term     (term)
  );

  assign acc_next = acc ^ term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   acc <= '0;
    else if (clr)                 acc <= '0;
    else if (accept && chunk_end) acc <= '0;
    else if (accept)              acc <= acc_next;
  end

  for (genvar g = 0; g < MAX_CHUNKS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    slot[g] <= '0;
      else if (clr)  slot[g] <= '0;
      else if (chunk_end && chunk_idx == CHUNK_W'(g)) slot[g] <= acc_next;
    end

    assert_pair_balance_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((slot[g].lo ^ slot[g].hi) == '0) || ((slot[g].lo ^ slot[g].hi) == '1));
    assert_slot_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (slot[g] == '0));
  end

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !clr) |=> $stable(acc));
endmodule

// File: rtl/hamm_ecc_gen.sv
module hamm_ecc_gen
  import hamm_ecc_pkg::*;
#(
  parameter int MAX_CHUNKS = 2,
  localparam int CHUNK_W = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1
)(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clr,
  input  logic                              page_big,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [BYTE_W-1:0]                 in_data,
  output logic [MAX_CHUNKS-1:0][POS_W-1:0]  par_lo,
  output logic [MAX_CHUNKS-1:0][POS_W-1:0]  par_hi,
  output logic                              done
);
  logic                  accept;
  logic                  chunk_end;
  logic [BYTE_IDX_W-1:0] byte_idx;
  logic [CHUNK_W-1:0]    chunk_idx;
  ecc_pair_t             slot [MAX_CHUNKS];

  hamm_ecc_ctrl #(.MAX_CHUNKS(MAX_CHUNKS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .page_big  (page_big),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .accept    (accept),
    .chunk_end (chunk_end),
    .byte_idx  (byte_idx),
    .chunk_idx (chunk_idx),
    .done      (done)
  );

  hamm_ecc_accum #(.MAX_CHUNKS(MAX_CHUNKS)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .accept    (accept),
    .chunk_end (chunk_end),
    .byte_idx  (byte_idx),
    .chunk_idx (chunk_idx),
    .data      (in_data),
    .slot      (slot)
  );

  for (genvar g = 0; g < MAX_CHUNKS; g++) begin : g_out
    assign par_lo[g] = slot[g].lo;
    assign par_hi[g] = slot[g].hi;
  end

  assert_hold_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> ($stable(par_lo) && $stable(par_hi)));
  assert_small_page_slot1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !page_big && !clr) |-> (par_lo[MAX_CHUNKS-1] == '0 || MAX_CHUNKS == 1));
endmodule

// File: tb/sim_hamm_ecc_gen.sv
`timescale 1ns/1ps
module sim_hamm_ecc_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic page_big = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = 8'h00;
  logic [1:0][10:0] par_lo;
  logic [1:0][10:0] par_hi;
  logic done;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [7:0] mem [0:511];
  int seed_dummy;

  always #2 clk = ~clk;

  hamm_ecc_gen u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .page_big(page_big),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .par_lo(par_lo), .par_hi(par_hi), .done(done)
  );

  function automatic logic [21:0] ref_pair(int base);
    logic [10:0] lo = '0;
    logic [10:0] hi = '0;
    for (int b = 0; b < 256; b++)
      for (int k = 0; k < 8; k++)
        if (mem[base + b][k]) begin
          lo ^= 11'(b * 8 + k);
          hi ^= ~11'(b * 8 + k);
        end
    return {hi, lo};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(int base, int n, int gap_pct);
    for (int i = 0; i < n; i++) begin
      while (($urandom % 100) < gap_pct) begin
        in_valid = 1'b0;
        in_data  = 8'($urandom);
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = mem[base + i];
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    in_valid = 1'b1;
    in_data = 8'hA5;
    #0;
    @(negedge clk);
    clr = 1'b0;
    in_valid = 1'b0;
  endtask

  task automatic fill_rand(int n);
    for (int i = 0; i < n; i++) mem[i] = 8'($urandom);
  endtask

  initial begin
    logic [21:0] e0, e1, a0;
    int p;
    seed_dummy = $urandom(32'd4242);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 lo0", 32'(par_lo[0]), 0);
    chk("R1 hi1", 32'(par_hi[1]), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 ready", 32'(in_ready), 1);

    // all-zero page, small size
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    page_big = 1'b0;
    do_clear();
    send(0, 255, 0);
    chk("R5 done early", 32'(done), 0);
    send(255, 1, 0);
    chk("R5 done", 32'(done), 1);
    chk("R2 zero page lo", 32'(par_lo[0]), 0);
    chk("R3 zero page hi", 32'(par_hi[0]), 0);

    // all-ones page: each group is XOR of its positions
    for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
    do_clear();
    chk("R8 cleared done", 32'(done), 0);
    send(0, 256, 0);
    e0 = ref_pair(0);
    chk("R2 ones lo", 32'(par_lo[0]), 32'(e0[10:0]));
    chk("R3 ones hi", 32'(par_hi[0]), 32'(e0[21:11]));

    // random small pages with gaps
    for (int t = 0; t < 4; t++) begin
      fill_rand(256);
      do_clear();
      send(0, 256, 30);
      e0 = ref_pair(0);
      chk("R2 rand lo", 32'(par_lo[0]), 32'(e0[10:0]));
      chk("R3 rand hi", 32'(par_hi[0]), 32'(e0[21:11]));
      chk("R9 gaps lo", 32'(par_lo[0]), 32'(e0[10:0]));
      chk("R5 slot1 lo", 32'(par_lo[1]), 0);
      chk("R5 slot1 hi", 32'(par_hi[1]), 0);
      chk("R10 balance", 32'((par_lo[0] ^ par_hi[0]) == 0 || (par_lo[0] ^ par_hi[0]) == 11'h7FF), 1);
    end

    // bytes after done are ignored
    chk("R7 ready low", 32'(in_ready), 0);
    for (int i = 0; i < 5; i++) begin
      in_valid = 1'b1;
      in_data = 8'($urandom);
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk("R7 lo hold", 32'(par_lo[0]), 32'(e0[10:0]));
    chk("R7 hi hold", 32'(par_hi[0]), 32'(e0[21:11]));
    chk("R7 done hold", 32'(done), 1);

    // clear: ready low during clear, state zeroed, restart at byte 0
    clr = 1'b1;
    #0;
    chk("R8 ready during clr", 32'(in_ready), 0);
    @(negedge clk);
    clr = 1'b0;
    chk("R8 lo zero", 32'(par_lo[0]), 0);
    chk("R8 hi zero", 32'(par_hi[0]), 0);
    chk("R8 done zero", 32'(done), 0);
    fill_rand(256);
    send(0, 256, 10);
    e0 = ref_pair(0);
    chk("R8 restart lo", 32'(par_lo[0]), 32'(e0[10:0]));

    // big pages
    for (int t = 0; t < 3; t++) begin
      fill_rand(512);
      page_big = 1'b1;
      do_clear();
      send(0, 256, 20);
      e0 = ref_pair(0);
      chk("R6 mid done", 32'(done), 0);
      chk("R6 mid lo0", 32'(par_lo[0]), 32'(e0[10:0]));
      send(256, 256, 20);
      e1 = ref_pair(256);
      chk("R6 done", 32'(done), 1);
      chk("R6 lo0", 32'(par_lo[0]), 32'(e0[10:0]));
      chk("R6 hi0", 32'(par_hi[0]), 32'(e0[21:11]));
      chk("R6 lo1", 32'(par_lo[1]), 32'(e1[10:0]));
      chk("R6 hi1", 32'(par_hi[1]), 32'(e1[21:11]));
      chk("R10 balance slot1", 32'((par_lo[1] ^ par_hi[1]) == 0 || (par_lo[1] ^ par_hi[1]) == 11'h7FF), 1);
    end

    // single-bit flips
    page_big = 1'b0;
    for (int t = 0; t < 6; t++) begin
      fill_rand(256);
      do_clear();
      send(0, 256, 5);
      a0 = {par_hi[0], par_lo[0]};
      p = (t == 0) ? 0 : (t == 1) ? 2047 : int'($urandom % 2048);
      mem[p / 8][p % 8] = ~mem[p / 8][p % 8];
      do_clear();
      send(0, 256, 5);
      chk("R4 syndrome addr", 32'(par_lo[0] ^ a0[10:0]), 32'(p));
      chk("R4 syndrome span", 32'(par_lo[0] ^ a0[10:0] ^ par_hi[0] ^ a0[21:11]), 32'h7FF);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule